// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Levels

This block holds the transmit and receive byte queues that sit between a serial bus engine and the software-facing register logic. Each direction has its own eight-entry first-in first-out store with a push port and a pop port. The register logic pushes bytes to be sent into the transmit queue, and the bus engine pops them. The bus engine pushes received bytes into the receive queue, and the register logic pops them.

Each queue compares its fill level with a programmable 3-bit threshold and raises a one-cycle event when the comparison becomes true. The two comparisons point in opposite directions. The transmit side asks for more data when its fill level has dropped to the threshold or below. The receive side asks for draining when its fill level has reached the threshold or above. The transmit status reports how many entries are still free. The receive status reports how many bytes are stored. Each queue also has a flush request that the user holds high. While the request is held, the queue empties and a flush-active status reads 1. Software releases the request once the status shows the queue is empty.

Further one-cycle events report that the receive queue became full, that a byte was pushed into a full receive queue, that a byte was popped from an empty transmit queue, and that the transmit queue has drained while the transmitter is idle.

Top module: `serial_byte_fifos`

## Requirements
- R1: After a synchronous reset, `tx_free` reads 8, `rx_count` reads 0, both flush-active outputs read 0, and no event output pulses while the inputs stay idle.
- R2: Bytes leave each queue in the order they entered. A pop accepted at a clock edge presents its byte on the pop-data output from that edge until the next accepted pop.
- R3: `tx_free` equals 8 minus the transmit occupancy, and `rx_count` equals the receive occupancy. Each is updated at the edge that accepts a push or a pop. A push and a pop accepted at the same edge leave the count unchanged.
- R4: A push into a full queue is dropped and the stored bytes are kept. On the receive side this raises `rx_overflow_evt` for one cycle, in the cycle after that edge.
- R5: A pop from an empty queue leaves the pop-data output unchanged. On the transmit side this raises `tx_underflow_evt` for one cycle, in the cycle after that edge.
- R6: `tx_trig_evt` pulses for one cycle when the transmit occupancy changes from greater than `tx_level` to less than or equal to `tx_level`. The pulse comes one cycle after the count changes.
- R7: `rx_trig_evt` pulses for one cycle when the receive occupancy changes from less than `rx_level` to greater than or equal to `rx_level`. The pulse comes one cycle after the count changes. With `rx_level` = 0 it never pulses.
- R8: `rx_full_evt` pulses for one cycle, one cycle after the receive occupancy first reaches 8.
- R9: `tx_empty_evt` pulses for one cycle on the transition into the state in which the transmit queue is empty and `tx_idle` is high. The pulse comes one cycle after that state begins. An empty queue with `tx_idle` low gives no pulse.
- R10: While a flush request is held, the queue is empty from the first edge on. Its flush-active output reads 1 from that edge until the edge after the request is released. Pushes and pops made during the flush are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to enqueue for transmission |
| tx_pop | input | 1 | Bus engine takes the next transmit byte |
| tx_pop_data | output | 8 | Most recently dequeued transmit byte |
| tx_level | input | 3 | Transmit threshold (occupancy at or below) |
| tx_flush | input | 1 | Held request to empty the transmit queue |
| tx_idle | input | 1 | Transmitter has finished shifting and is idle |
| tx_free | output | 4 | Free transmit entries |
| tx_flush_active | output | 1 | Transmit flush in progress |
| tx_trig_evt | output | 1 | Transmit threshold event pulse |
| tx_empty_evt | output | 1 | Transmit drained-and-idle event pulse |
| tx_underflow_evt | output | 1 | Pop from empty transmit queue pulse |
| rx_push | input | 1 | Bus engine stores a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Register logic takes the next received byte |
| rx_pop_data | output | 8 | Most recently dequeued received byte |
| rx_level | input | 3 | Receive threshold (occupancy at or above) |
| rx_flush | input | 1 | Held request to empty the receive queue |
| rx_count | output | 4 | Stored receive bytes |
| rx_flush_active | output | 1 | Receive flush in progress |
| rx_trig_evt | output | 1 | Receive threshold event pulse |
| rx_full_evt | output | 1 | Receive queue became full pulse |
| rx_overflow_evt | output | 1 | Push into full receive queue pulse |

## Verification
The queues are exercised with separate push bursts, drains and same-cycle push/pop traffic. These tell in-order delivery apart from pointer or count slips. Thresholds are crossed in both directions with levels in mid range and at 0, which separates an edge-triggered event from a level and an inverted comparison from a correct one. Pushing past eight bytes and popping past empty separates dropping the byte from overwriting or wrapping. Holding a flush while pushing separates an ignored push from one that gets through.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  byte_t                        push_data,
  input  logic                         pop,
  output byte_t                        pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_full_pulse,
  output logic                         pop_empty_pulse
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  byte_t             mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr          <= '0;
      rd_ptr          <= '0;
      count           <= '0;
      pop_data        <= '0;
      push_full_pulse <= 1'b0;
      pop_empty_pulse <= 1'b0;
    end else begin
      push_full_pulse <= push && full && !flush;
      pop_empty_pulse <= pop && empty && !flush;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + 1'b1;
        if (pop_ok) begin
          rd_ptr   <= rd_ptr + 1'b1;
          pop_data <= mem[rd_ptr];
        end
        if (push_ok && !pop_ok)      count <= count + 1'b1;
        else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfifo_events.sv
module sfifo_events #(
  parameter int DEPTH = 8,
  parameter bit IS_TX = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [$clog2(DEPTH)-1:0]     level,
  input  logic                         aux,
  output logic                         trig_evt,
  output logic                         edge_evt
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int LVL_W = $clog2(DEPTH);
  // condition values of an empty queue, used as reset history
  localparam bit TRIG_RST = IS_TX;
  localparam bit EDGE_RST = IS_TX;

  logic [CNT_W-1:0] level_ext;
  logic             trig_cond, edge_cond, trig_q, edge_q;

  assign level_ext = {{(CNT_W-LVL_W){1'b0}}, level};

  generate
    if (IS_TX) begin : g_tx
      assign trig_cond = (count <= level_ext);
      assign edge_cond = (count == '0) && aux;
    end else begin : g_rx
      assign trig_cond = (level != '0) && (count >= level_ext);
      assign edge_cond = (count == CNT_W'(DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= TRIG_RST;
      edge_q   <= EDGE_RST;
      trig_evt <= 1'b0;
      edge_evt <= 1'b0;
    end else begin
      trig_q   <= trig_cond;
      edge_q   <= edge_cond;
      trig_evt <= trig_cond && !trig_q;
      edge_evt <= edge_cond && !edge_q;
    end
  end
endmodule

// File: rtl/serial_byte_fifos.sv
module serial_byte_fifos
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tx_push,
  input  logic [7:0]                   tx_push_data,
  input  logic                         tx_pop,
  output logic [7:0]                   tx_pop_data,
  input  logic [$clog2(DEPTH)-1:0]     tx_level,
  input  logic                         tx_flush,
  input  logic                         tx_idle,
  output logic [$clog2(DEPTH+1)-1:0]   tx_free,
  output logic                         tx_flush_active,
  output logic                         tx_trig_evt,
  output logic                         tx_empty_evt,
  output logic                         tx_underflow_evt,
  input  logic                         rx_push,
  input  logic [7:0]                   rx_push_data,
  input  logic                         rx_pop,
  output logic [7:0]                   rx_pop_data,
  input  logic [$clog2(DEPTH)-1:0]     rx_level,
  input  logic                         rx_flush,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         rx_flush_active,
  output logic                         rx_trig_evt,
  output logic                         rx_full_evt,
  output logic                         rx_overflow_evt
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] tx_used;
  logic             tx_full_unused, rx_empty_unused, rx_unf_unused;

  sfifo_store #(.DEPTH(DEPTH)) u_tx_store (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(tx_push_data),
    .pop(tx_pop), .pop_data(tx_pop_data), .count(tx_used),
    .push_full_pulse(tx_full_unused), .pop_empty_pulse(tx_underflow_evt)
  );

  sfifo_store #(.DEPTH(DEPTH)) u_rx_store (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .push_data(rx_push_data),
    .pop(rx_pop), .pop_data(rx_pop_data), .count(rx_count),
    .push_full_pulse(rx_overflow_evt), .pop_empty_pulse(rx_unf_unused)
  );

  sfifo_events #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_evt (
    .clk(clk), .rst(rst), .count(tx_used), .level(tx_level), .aux(tx_idle),
    .trig_evt(tx_trig_evt), .edge_evt(tx_empty_evt)
  );

  sfifo_events #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_evt (
    .clk(clk), .rst(rst), .count(rx_count), .level(rx_level), .aux(1'b0),
    .trig_evt(rx_trig_evt), .edge_evt(rx_full_evt)
  );

  // rx_empty_unused marks the receive empty-pop pulse as deliberately unused
  assign rx_empty_unused = rx_unf_unused | tx_full_unused;

  assign tx_free = CNT_W'(DEPTH) - tx_used;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush_active <= 1'b0;
      rx_flush_active <= 1'b0;
    end else begin
      tx_flush_active <= tx_flush;
      rx_flush_active <= rx_flush;
    end
  end
endmodule

// File: rtl/serial_byte_fifos_checker.sv
module serial_byte_fifos_checker #(
  parameter int DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [$clog2(DEPTH+1)-1:0]  tx_free,
  input logic [$clog2(DEPTH+1)-1:0]  rx_count,
  input logic [$clog2(DEPTH)-1:0]    rx_level,
  input logic                        rx_flush_active,
  input logic                        tx_flush_active,
  input logic                        tx_trig_evt,
  input logic                        rx_trig_evt,
  input logic                        rx_full_evt,
  input logic                        rx_overflow_evt,
  input logic                        tx_underflow_evt
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_free <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    rx_overflow_evt |-> $past(rx_count) == CNT_W'(DEPTH));

  assert_underflow_empty_R5: assert property (@(posedge clk) disable iff (rst)
    tx_underflow_evt |-> $past(tx_free) == CNT_W'(DEPTH));

  assert_trig_single_R6: assert property (@(posedge clk) disable iff (rst)
    tx_trig_evt |=> !tx_trig_evt);

  assert_rx_level_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rx_trig_evt |-> $past(rx_level) != '0);

  assert_full_event_R8: assert property (@(posedge clk) disable iff (rst)
    rx_full_evt |-> $past(rx_count) == CNT_W'(DEPTH));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_flush_active |-> rx_count == '0) and
    (tx_flush_active |-> tx_free == CNT_W'(DEPTH)));
endmodule

bind serial_byte_fifos serial_byte_fifos_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tx_free(tx_free), .rx_count(rx_count),
  .rx_level(rx_level), .rx_flush_active(rx_flush_active),
  .tx_flush_active(tx_flush_active), .tx_trig_evt(tx_trig_evt),
  .rx_trig_evt(rx_trig_evt), .rx_full_evt(rx_full_evt),
  .rx_overflow_evt(rx_overflow_evt), .tx_underflow_evt(tx_underflow_evt)
);

// File: tb/serial_byte_fifos_test.sv
module serial_byte_fifos_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_push = 0, tx_pop = 0, tx_flush = 0, tx_idle = 0;
  logic rx_push = 0, rx_pop = 0, rx_flush = 0;
  logic [7:0] tx_push_data = 0, rx_push_data = 0;
  logic [2:0] tx_level = 0, rx_level = 0;
  logic [7:0] tx_pop_data, rx_pop_data;
  logic [3:0] tx_free, rx_count;
  logic tx_flush_active, tx_trig_evt, tx_empty_evt, tx_underflow_evt;
  logic rx_flush_active, rx_trig_evt, rx_full_evt, rx_overflow_evt;

  int errors = 0, checks = 0;
  int n_txtrig = 0, n_txempty = 0, n_unf = 0, n_rxtrig = 0, n_full = 0, n_ovf = 0;

  always #2 clk = ~clk;

  serial_byte_fifos uut (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_level(tx_level), .tx_flush(tx_flush),
    .tx_idle(tx_idle), .tx_free(tx_free), .tx_flush_active(tx_flush_active),
    .tx_trig_evt(tx_trig_evt), .tx_empty_evt(tx_empty_evt),
    .tx_underflow_evt(tx_underflow_evt),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .rx_level(rx_level), .rx_flush(rx_flush),
    .rx_count(rx_count), .rx_flush_active(rx_flush_active),
    .rx_trig_evt(rx_trig_evt), .rx_full_evt(rx_full_evt),
    .rx_overflow_evt(rx_overflow_evt)
  );

  always @(negedge clk) if (!rst) begin
    if (tx_trig_evt) n_txtrig++;
    if (tx_empty_evt) n_txempty++;
    if (tx_underflow_evt) n_unf++;
    if (rx_trig_evt) n_rxtrig++;
    if (rx_full_evt) n_full++;
    if (rx_overflow_evt) n_ovf++;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic txw(logic [7:0] d);
    tx_push = 1; tx_push_data = d; tick(); tx_push = 0;
  endtask
  task automatic txr(); tx_pop = 1; tick(); tx_pop = 0; endtask
  task automatic rxw(logic [7:0] d);
    rx_push = 1; rx_push_data = d; tick(); rx_push = 0;
  endtask
  task automatic rxr(); rx_pop = 1; tick(); rx_pop = 0; endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1 tx_free", tx_free, 8);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 flush flags", {tx_flush_active, rx_flush_active}, 0);
    chk("R1 no events", n_txtrig + n_txempty + n_unf + n_rxtrig + n_full + n_ovf, 0);
  endtask

  task automatic t_order();
    txw(8'hA1); txw(8'hB2); txw(8'hC3);
    chk("R3 free after 3 pushes", tx_free, 5);
    txr();
    chk("R2 first out", tx_pop_data, 8'hA1);
    chk("R3 free after pop", tx_free, 6);
    tx_push = 1; tx_push_data = 8'hD4; tx_pop = 1; tick(); tx_push = 0; tx_pop = 0;
    chk("R2 second out", tx_pop_data, 8'hB2);
    chk("R3 push+pop same edge", tx_free, 6);
    txr(); chk("R2 third out", tx_pop_data, 8'hC3);
    txr(); chk("R2 fourth out", tx_pop_data, 8'hD4);
    chk("R3 drained", tx_free, 8);
    tick(); tick();
  endtask

  task automatic t_tx_trig();
    int base;
    tx_level = 3'd2; tick(); tick();
    base = n_txtrig;
    txw(1); txw(2); txw(3); tick(); tick();
    chk("R6 no pulse rising above level", n_txtrig - base, 0);
    txr(); tick(); tick();
    chk("R6 pulse entering <= level", n_txtrig - base, 1);
    txr(); txr(); tick(); tick();
    chk("R6 single pulse while staying below", n_txtrig - base, 1);
  endtask

  task automatic t_tx_empty();
    int base = n_txempty;
    txw(8'h11); txr(); tick(); tick();
    chk("R9 no pulse while not idle", n_txempty - base, 0);
    tx_idle = 1; tick(); tick(); tick();
    chk("R9 pulse when empty and idle", n_txempty - base, 1);
    tx_idle = 0; tick();
  endtask

  task automatic t_rx_trig();
    int base;
    rx_level = 3'd3; tick(); tick();
    base = n_rxtrig;
    rxw(1); rxw(2); tick(); tick();
    chk("R7 below level no pulse", n_rxtrig - base, 0);
    rxw(3); tick(); tick();
    chk("R7 pulse reaching level", n_rxtrig - base, 1);
    rxw(4); tick(); tick();
    chk("R7 no repeat above level", n_rxtrig - base, 1);
    rxr(); rxr(); rxr(); rxr();
    chk("R3 rx drained", rx_count, 0);
    rx_level = 3'd0; tick(); tick();
    base = n_rxtrig;
    rxw(5); rxw(6); tick(); tick();
    chk("R7 level 0 never fires", n_rxtrig - base, 0);
    rxr(); rxr(); tick();
  endtask

  task automatic t_full_ovf();
    int bf = n_full, bo = n_ovf;
    for (int i = 0; i < 8; i++) rxw(8'h10 + 8'(i));
    chk("R3 rx count full", rx_count, 8);
    tick(); tick();
    chk("R8 full pulse", n_full - bf, 1);
    chk("R4 no overflow yet", n_ovf - bo, 0);
    rxw(8'hEE); tick();
    chk("R4 overflow pulse", n_ovf - bo, 1);
    chk("R4 count stays 8", rx_count, 8);
    for (int i = 0; i < 8; i++) begin
      rxr();
      chk("R4 stored data kept", rx_pop_data, 8'h10 + i);
    end
    chk("R3 rx empty", rx_count, 0);
  endtask

  task automatic t_underflow();
    int base = n_unf;
    txw(8'h5A); txr();
    chk("R2 pop data", tx_pop_data, 8'h5A);
    txr(); tick();
    chk("R5 pop data held", tx_pop_data, 8'h5A);
    chk("R5 underflow pulse", n_unf - base, 1);
    chk("R5 free stays 8", tx_free, 8);
  endtask

  task automatic t_flush();
    rxw(1); rxw(2); rxw(3);
    chk("R3 rx count 3", rx_count, 3);
    rx_flush = 1; tick();
    chk("R10 rx emptied", rx_count, 0);
    chk("R10 rx flush active", rx_flush_active, 1);
    rxw(8'h99); tick();
    chk("R10 push ignored in flush", rx_count, 0);
    rx_flush = 0; tick();
    chk("R10 flush active released", rx_flush_active, 0);
    rxw(8'h77); rxr();
    chk("R10 works after flush", rx_pop_data, 8'h77);
    txw(1); txw(2);
    tx_flush = 1; tick();
    chk("R10 tx free restored", tx_free, 8);
    chk("R10 tx flush active", tx_flush_active, 1);
    tx_flush = 0; tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_order();
    t_tx_trig();
    t_tx_empty();
    t_rx_trig();
    t_full_ovf();
    t_underflow();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule